// File: doc/BRIEF.md
# Indirect Register Window for an Interrupt Routing Controller

This block is the register front end of an interrupt routing controller. A bus master reaches all of the controller's configuration through two addresses only. One address holds a latched register index. The other address is a data window onto whichever register that index names. The registers behind the window are an identification register, a fixed version word, an arbitration word that always reads zero, and a table with one 64-bit routing entry per interrupt input. Each table entry takes two consecutive indices: one for its lower 32 bits and one for its upper 32 bits.

The bus is a plain valid/ready request channel with a registered response. Every table write also appears on a write port, which shows the entry number, the half and the data. One cycle after the write, the block raises a one-cycle scan request so that the delivery logic can look at the pending inputs again.

Top module: `irq_regwin`

## Requirements
- R1: Only the low 8 address bits are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. A read of any other offset returns 0, and a write to it changes nothing.
- R2: A write to the select offset latches wdata[7:0], whatever the access size. A read of the select offset returns the latched index, zero-extended to 32 bits.
- R3: A window access whose size code is not 2 (size codes 0/1/2/3 = 1/2/4/8 bytes) reads as 0 and its write has no effect.
- R4: Index 0x01 is the version word. It reads as 0x11 ORed with (NPINS-1) in bits [23:16], which is 0x00170011 for 24 inputs. Writes to it are ignored.
- R5: Index 0x02 always reads as 0, and writes to it are ignored.
- R6: Index 0x00 is the identification register. A write stores wdata[27:24]. A read returns the stored value in bits [27:24] and zero in all other bits.
- R7: An index i at or above 0x10 selects entry (i-0x10)/2. An odd index reaches bits [63:32] of that entry and an even index reaches bits [31:0]. A write changes only the addressed half.
- R8: An index that is not 0x00-0x02 and not a valid table index (0x03-0x0F, or an entry number of NPINS or more) reads as 0 and ignores writes. Such a write produces no write-port strobe.
- R9: Every accepted table write asserts the write strobe in its acceptance cycle, with the entry number and half on the write port. It raises scan_req for exactly the following cycle. No other access raises scan_req.
- R10: req_ready is always high. rsp_valid is high in the cycle after each accepted request. The response data of a write is 0.
- R11: After reset, the select index, the identification value and every table entry are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; only bits [7:0] are decoded |
| req_size | input | 2 | log2 of access bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data |
| tbl_we | output | 1 | Table write strobe |
| tbl_entry | output | ENT_W | Entry being written |
| tbl_upper | output | 1 | 1 = bits [63:32] are written |
| tbl_wdata | output | 32 | Data for the written half |
| scan_req | output | 1 | One-cycle scan request after a table write |

## Verification
The embedded assertions check the following on every cycle: scan_req is paired with a table write one cycle earlier, every request gets a response, the select and identification registers stay unchanged without their strobe, at most one write strobe is active, a table write never names an entry outside the table, and writing one half leaves the other half unchanged. The read values themselves are checked only by the bench's scenarios. These are the index-to-half mapping, the version encoding, zero reads for narrow, out-of-range and unmapped accesses, and aliasing of the upper address bits. The bench compares them against a reference model of the register file that it keeps itself.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;

  localparam int unsigned SEL_W  = 8;
  localparam int unsigned DATA_W = 32;
  localparam logic [1:0]  SIZE_WORD = 2'd2;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_TBL
  } tgt_e;

  // version word: code in [7:0], highest entry number in [23:16]
  function automatic logic [DATA_W-1:0] ver_word(int unsigned npins, logic [7:0] code);
    logic [7:0] top_idx;
    top_idx = 8'(npins - 1);
    return {8'h00, top_idx, 8'h00, code};
  endfunction

  // relative table slot of a select index
  function automatic logic [SEL_W-2:0] tbl_slot(logic [SEL_W-1:0] sel, logic [SEL_W-1:0] base);
    logic [SEL_W-1:0] rel;
    rel = sel - base;
    return rel[SEL_W-1:1];
  endfunction

  function automatic logic tbl_hit(logic [SEL_W-1:0] sel, logic [SEL_W-1:0] base,
                                   int unsigned npins);
    return (sel >= base) && (32'(tbl_slot(sel, base)) < npins);
  endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import irq_regwin_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NPINS    = 24,
  parameter int unsigned ENT_W    = 5,
  parameter logic [7:0]  SEL_OFF  = 8'h00,
  parameter logic [7:0]  WIN_OFF  = 8'h10,
  parameter logic [7:0]  REG_ID   = 8'h00,
  parameter logic [7:0]  REG_VER  = 8'h01,
  parameter logic [7:0]  REG_ARB  = 8'h02,
  parameter logic [7:0]  TBL_BASE = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [SEL_W-1:0]  sel_q,
  output logic              acc_sel,
  output logic              acc_win,
  output tgt_e              tgt,
  output logic              sel_we,
  output logic              id_we,
  output logic              tbl_we,
  output logic [ENT_W-1:0]  tbl_entry,
  output logic              tbl_upper
);

  logic [7:0] off;
  logic       wr_acc;

  assign off = req_addr[7:0];

  generate
    if (ADDR_W > 8) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^req_addr[ADDR_W-1:8];
    end
  endgenerate

  assign acc_sel = (off == SEL_OFF);
  assign acc_win = (off == WIN_OFF) && (req_size == SIZE_WORD);
  assign wr_acc  = req_valid && req_write;

  always_comb begin
    tgt = TGT_NONE;
    if (sel_q == REG_ID)                       tgt = TGT_ID;
    else if (sel_q == REG_VER)                 tgt = TGT_VER;
    else if (sel_q == REG_ARB)                 tgt = TGT_ARB;
    else if (tbl_hit(sel_q, TBL_BASE, NPINS))  tgt = TGT_TBL;
  end

  assign tbl_entry = ENT_W'(tbl_slot(sel_q, TBL_BASE));
  assign tbl_upper = sel_q[0];
  assign sel_we    = wr_acc && acc_sel;
  assign id_we     = wr_acc && acc_win && (tgt == TGT_ID);
  assign tbl_we    = wr_acc && acc_win && (tgt == TGT_TBL);

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_we, id_we, tbl_we}));

  assert_entry_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (32'(tbl_entry) < NPINS));

endmodule

// File: rtl/regwin_regs.sv
module regwin_regs
  import irq_regwin_pkg::*;
#(
  parameter int unsigned ID_LSB = 24,
  parameter int unsigned ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic              id_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic [ID_W-1:0]   id_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_we) sel_q <= wdata[SEL_W-1:0];
      if (id_we)  id_q  <= wdata[ID_LSB +: ID_W];
    end
  end

  assert_sel_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(sel_q));

  assert_id_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !id_we |=> $stable(id_q));

endmodule

// File: rtl/regwin_table.sv
module regwin_table
  import irq_regwin_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  parameter int unsigned ENT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ENT_W-1:0]  wr_entry,
  input  logic              wr_upper,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ENT_W-1:0]  rd_entry,
  input  logic              rd_upper,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] lo_q [NPINS];
  logic [DATA_W-1:0] hi_q [NPINS];

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_ent
      logic hit_w;
      assign hit_w = wr_en && (32'(wr_entry) == g);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lo_q[g] <= '0;
          hi_q[g] <= '0;
        end else if (hit_w) begin
          if (wr_upper) hi_q[g] <= wr_data;
          else          lo_q[g] <= wr_data;
        end
      end

      assert_lower_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w && wr_upper) |=> $stable(lo_q[g]));

      assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w && !wr_upper) |=> $stable(hi_q[g]));
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (32'(rd_entry) < NPINS)
      rd_data = rd_upper ? hi_q[rd_entry] : lo_q[rd_entry];
  end

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
  import irq_regwin_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NPINS    = 24,
  parameter logic [7:0]  SEL_OFF  = 8'h00,
  parameter logic [7:0]  WIN_OFF  = 8'h10,
  parameter logic [7:0]  REG_ID   = 8'h00,
  parameter logic [7:0]  REG_VER  = 8'h01,
  parameter logic [7:0]  REG_ARB  = 8'h02,
  parameter logic [7:0]  TBL_BASE = 8'h10,
  parameter logic [7:0]  VER_CODE = 8'h11,
  parameter int unsigned ID_LSB   = 24,
  parameter int unsigned ID_W     = 4,
  localparam int unsigned ENT_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              tbl_we,
  output logic [ENT_W-1:0]  tbl_entry,
  output logic              tbl_upper,
  output logic [31:0]       tbl_wdata,
  output logic              scan_req
);

  logic              acc_sel, acc_win, sel_we, id_we;
  tgt_e              tgt;
  logic [SEL_W-1:0]  sel_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] tbl_rd, rd_next;

  assign req_ready = 1'b1;
  assign tbl_wdata = req_wdata;

  regwin_decode #(
    .ADDR_W(ADDR_W), .NPINS(NPINS), .ENT_W(ENT_W), .SEL_OFF(SEL_OFF), .WIN_OFF(WIN_OFF),
    .REG_ID(REG_ID), .REG_VER(REG_VER), .REG_ARB(REG_ARB), .TBL_BASE(TBL_BASE)
  ) decode_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .sel_q(sel_q),
    .acc_sel(acc_sel), .acc_win(acc_win), .tgt(tgt), .sel_we(sel_we), .id_we(id_we),
    .tbl_we(tbl_we), .tbl_entry(tbl_entry), .tbl_upper(tbl_upper)
  );

  regwin_regs #(.ID_LSB(ID_LSB), .ID_W(ID_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .id_we(id_we), .wdata(req_wdata),
    .sel_q(sel_q), .id_q(id_q)
  );

  regwin_table #(.NPINS(NPINS), .ENT_W(ENT_W)) table_i (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_entry(tbl_entry), .wr_upper(tbl_upper),
    .wr_data(req_wdata), .rd_entry(tbl_entry), .rd_upper(tbl_upper), .rd_data(tbl_rd)
  );

  always_comb begin
    rd_next = '0;
    if (acc_sel) begin
      rd_next = DATA_W'(sel_q);
    end else if (acc_win) begin
      case (tgt)
        TGT_ID:  rd_next = DATA_W'(id_q) << ID_LSB;
        TGT_VER: rd_next = ver_word(NPINS, VER_CODE);
        TGT_TBL: rd_next = tbl_rd;
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      scan_req  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_next : '0;
      scan_req  <= tbl_we;
    end
  end

  assert_scan_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> scan_req);

  assert_scan_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_req |-> $past(tbl_we));

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

endmodule

// File: tb/irq_regwin_tb_top.sv
`timescale 1ns/1ps
module irq_regwin_tb_top;

  localparam int NP = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, tbl_we, tbl_upper, scan_req;
  logic [31:0] rsp_rdata, tbl_wdata;
  logic [4:0]  tbl_entry;

  int n_chk = 0, n_bad = 0;

  // reference state
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic [31:0] m_lo [NP];
  logic [31:0] m_hi [NP];

  always #2.5 clk = ~clk;

  irq_regwin dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tbl_we(tbl_we), .tbl_entry(tbl_entry),
    .tbl_upper(tbl_upper), .tbl_wdata(tbl_wdata), .scan_req(scan_req)
  );

  task automatic check(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic in_tbl(input logic [7:0] s);
    return (s >= 8'h10) && (((int'(s) - 16) / 2) < NP);
  endfunction

  function automatic string req_of(input logic [11:0] a, input logic [1:0] sz);
    if (a[7:0] == 8'h00) return "R2";
    if (a[7:0] != 8'h10) return "R1";
    if (sz != 2'd2)      return "R3";
    if (m_sel == 8'h00)  return "R6";
    if (m_sel == 8'h01)  return "R4";
    if (m_sel == 8'h02)  return "R5";
    if (in_tbl(m_sel))   return "R7";
    return "R8";
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [1:0] sz);
    int e;
    if (a[7:0] == 8'h00) return {24'h0, m_sel};
    if (a[7:0] != 8'h10 || sz != 2'd2) return 32'h0;
    case (m_sel)
      8'h00: return {4'h0, m_id, 24'h0};
      8'h01: return 32'h11 | (32'(NP - 1) << 16);
      8'h02: return 32'h0;
      default: ;
    endcase
    if (!in_tbl(m_sel)) return 32'h0;
    e = (int'(m_sel) - 16) / 2;
    return m_sel[0] ? m_hi[e] : m_lo[e];
  endfunction

  task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] wd);
    string rq;
    logic [31:0] er;
    logic exp_we;
    int e;
    rq = req_of(a, sz);
    er = wr ? 32'h0 : exp_read(a, sz);
    exp_we = wr && a[7:0] == 8'h10 && sz == 2'd2 && in_tbl(m_sel);
    e = (int'(m_sel) - 16) / 2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    #1;
    check("R10", "ready", {31'h0, req_ready}, 32'h1);
    check(exp_we ? "R9" : rq, "write strobe", {31'h0, tbl_we}, {31'h0, exp_we});
    if (exp_we) begin
      check("R7", "strobe entry", 32'(tbl_entry), 32'(e));
      check("R7", "strobe half", {31'h0, tbl_upper}, {31'h0, m_sel[0]});
      check("R9", "strobe data", tbl_wdata, wd);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "rsp_valid", {31'h0, rsp_valid}, 32'h1);
    check(wr ? "R10" : rq, "read data", rsp_rdata, er);
    check("R9", "scan pulse", {31'h0, scan_req}, {31'h0, exp_we});
    if (wr) begin
      if (a[7:0] == 8'h00) m_sel = wd[7:0];
      else if (a[7:0] == 8'h10 && sz == 2'd2) begin
        if (m_sel == 8'h00) m_id = wd[27:24];
        else if (exp_we) begin
          if (m_sel[0]) m_hi[e] = wd; else m_lo[e] = wd;
        end
      end
    end
  endtask

  task automatic rd(input logic [11:0] a); access(1'b0, a, 2'd2, 32'h0); endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d); access(1'b1, a, 2'd2, d); endtask

  initial begin : watchdog
    #(5 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h1F2E3D4C));
    m_sel = '0; m_id = '0;
    for (int i = 0; i < NP; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    check("R11", "scan at reset", {31'h0, scan_req}, 32'h0);
    check("R11", "rsp at reset", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset contents
    rd(12'h000);
    rd(12'h010);
    wr(12'h000, 32'h10); rd(12'h010);
    wr(12'h000, 32'h3F); rd(12'h010);

    // R4 version and R5 arbitration, writes ignored
    wr(12'h000, 32'h01); rd(12'h010); wr(12'h010, 32'hFFFFFFFF); rd(12'h010);
    wr(12'h000, 32'h02); wr(12'h010, 32'hFFFFFFFF); rd(12'h010);

    // R6 id field only
    wr(12'h000, 32'h00); wr(12'h010, 32'hA5FFFFFF); rd(12'h010);

    // R7 halves independent
    wr(12'h000, 32'h15); wr(12'h010, 32'hDEADBEEF);
    wr(12'h000, 32'h14); wr(12'h010, 32'h12345678); rd(12'h010);
    wr(12'h000, 32'h15); rd(12'h010);

    // R8 out of range indices
    wr(12'h000, 32'h40); wr(12'h010, 32'h55AA55AA); rd(12'h010);
    wr(12'h000, 32'h07); wr(12'h010, 32'h55AA55AA); rd(12'h010);

    // R3 narrow window accesses
    wr(12'h000, 32'h14);
    access(1'b1, 12'h010, 2'd1, 32'hCAFEF00D); access(1'b0, 12'h010, 2'd0, 32'h0);
    rd(12'h010);

    // R1 aliasing of upper bits and unmapped offsets
    wr(12'hF00, 32'h16); rd(12'h700); rd(12'hA10);
    wr(12'h004, 32'h77777777); rd(12'h004); rd(12'h000);

    // constrained random
    for (int k = 0; k < 2000; k++) begin
      int r;
      logic [11:0] a;
      logic [1:0] sz;
      r = int'($urandom % 10);
      a[11:8] = 4'($urandom);
      sz = (($urandom % 8) == 0) ? 2'($urandom) : 2'd2;
      if (r < 3) begin
        a[7:0] = 8'h00;
        access(1'b1, a, sz, (($urandom % 6) == 0) ? $urandom : 32'($urandom % 72));
      end else if (r < 6) begin
        a[7:0] = 8'h10;
        access(1'b1, a, sz, $urandom);
      end else if (r < 9) begin
        a[7:0] = 8'h10;
        access(1'b0, a, sz, 32'h0);
      end else begin
        a[7:0] = (($urandom % 2) == 0) ? 8'h00 : 8'($urandom);
        access($urandom_range(0, 1) == 1, a, sz, $urandom);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule